// File: doc/BRIEF.md
# ChaCha20 Keystream Block Generator

This block produces a run of consecutive ChaCha20 keystream blocks for a 256-bit key. The nonce is fixed at zero and the block counter is a full 64 bits. A caller loads a key, a starting counter and the number of 64-byte blocks it wants, then pulses a start input. The core applies one double round per clock, so each block takes ten clocks of mixing. It adds the starting state back in and streams the block out as sixteen 32-bit words over a valid/ready interface.

After the last word of a block is accepted, the counter advances by one and the next block begins mixing. When the requested run is finished, the block pulses a done flag and presents the advanced counter so the caller can resume from it. At the same time it clears its working state and its copy of the key. Keystream bytes are little-endian within each word, and word 0 is sent first.

Top module: `chacha_kstream_gen`

## Requirements
- R1: While reset is held and right after it, `busy_o`, `valid_o` and `done_o` are 0. `valid_o` is only ever high while `busy_o` is high.
- R2: The initial state follows a fixed word layout, with word index = 4*row + lane. Words 0..3 are 0x61707865, 0x3320646e, 0x79622d32, 0x6b206574. Words 4..11 are key words 0..7, where key word i is `key_i[32*i+31:32*i]`. Word 12 is `ctr[31:0]` and word 13 is `ctr[63:32]`. Words 14 and 15 are zero.
- R3: Mixing runs 20 rounds as 10 double rounds, one per clock. A double round is four column quarter-rounds followed by four diagonal quarter-rounds. `valid_o` first rises on the 10th rising edge after the edge that accepts start.
- R4: Output word k of a block is mixed word k plus initial word k, modulo 2^32. The words are streamed for k = 0..15, and a word advances only on an edge where `valid_o` and `ready_i` are both high. While `valid_o` is high and `ready_i` is low, `word_o` holds its value.
- R5: Block b of a job uses counter start+b, computed modulo 2^64, so the carry from the low word reaches the high word and the all-ones counter wraps to zero. `ctr_o` rises by exactly one on each edge that accepts the last word of a block.
- R6: The next block starts mixing only after the last word of the current block is accepted. `valid_o` is then low for exactly 10 clocks.
- R7: `done_o` is high for one clock, starting at the edge that accepts the final word of the job. `busy_o` falls on that same edge, and `ctr_o` then equals start + count (mod 2^64).
- R8: A start pulse while `busy_o` is high is ignored. The running job's output words and counter are unchanged by it.
- R9: When `done_o` is high, the internal working state and the stored key are all zeros. `word_o` reads 0 whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a job (sampled only while idle) |
| key_i | input | 256 | Key, word i in bits 32*i+31:32*i |
| ctr_i | input | 64 | Starting block counter |
| nblk_i | input | NBLK_W | Number of blocks to produce (nonzero) |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-clock completion pulse |
| word_o | output | 32 | Keystream word |
| valid_o | output | 1 | `word_o` is valid |
| ready_i | input | 1 | Consumer accepts `word_o` |
| ctr_o | output | 64 | Current counter; after done, the resume value |

## Verification
The assertions assume that `nblk_i` is nonzero whenever a start is accepted; a zero count would wrap the remaining-block counter. They also assume that `ready_i` may change on any cycle, independent of `valid_o`. The stimulus only requests counts from one to three. It drives ready as always-high, as pseudo-random, or as mostly low, so that the hold rule and the end-of-block gap are exercised under back-pressure. Start pulses during a job carry a different key and counter, so any effect would show up in the scored words.

// File: rtl/chacha_kstream_pkg.sv
package chacha_kstream_pkg;

  localparam int WORD_W = 32;
  localparam int N_WORDS = 16;
  localparam int KEY_W = 256;
  localparam int CTR_W = 64;
  localparam int IDX_W = $clog2(N_WORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [N_WORDS-1:0][WORD_W-1:0] blk_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROUND = 2'd1,
    ST_EMIT  = 2'd2
  } ks_state_t;

  // "expand 32-byte k" as four little-endian words
  localparam word_t SIGMA0 = 32'h61707865;
  localparam word_t SIGMA1 = 32'h3320646e;
  localparam word_t SIGMA2 = 32'h79622d32;
  localparam word_t SIGMA3 = 32'h6b206574;

  function automatic word_t rotl(input word_t v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic blk_t init_state(input logic [KEY_W-1:0] key,
                                      input logic [CTR_W-1:0] ctr);
    blk_t s;
    s[0] = SIGMA0;
    s[1] = SIGMA1;
    s[2] = SIGMA2;
    s[3] = SIGMA3;
    for (int i = 0; i < 8; i++) begin
      s[4+i] = key[WORD_W*i +: WORD_W];
    end
    s[12] = ctr[31:0];
    s[13] = ctr[63:32];
    s[14] = '0;
    s[15] = '0;
    return s;
  endfunction

endpackage

// File: rtl/ks_qround.sv
module ks_qround
  import chacha_kstream_pkg::*;
(
  input  word_t a_i,
  input  word_t b_i,
  input  word_t c_i,
  input  word_t d_i,
  output word_t a_o,
  output word_t b_o,
  output word_t c_o,
  output word_t d_o
);

  word_t a1, b1, c1, d1;
  word_t a2, b2, c2, d2;

  // first half: add/xor/rotate by 16 then 12
  always_comb begin
    a1 = a_i + b_i;
    d1 = rotl(d_i ^ a1, 16);
    c1 = c_i + d1;
    b1 = rotl(b_i ^ c1, 12);
  end

  // second half: rotate by 8 then 7
  always_comb begin
    a2 = a1 + b1;
    d2 = rotl(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rotl(b1 ^ c2, 7);
  end

  assign a_o = a2;
  assign b_o = b2;
  assign c_o = c2;
  assign d_o = d2;

endmodule

// File: rtl/ks_dround.sv
module ks_dround
  import chacha_kstream_pkg::*;
(
  input  blk_t s_i,
  output blk_t s_o
);

  blk_t col;

  // column pass: lane l of every row
  for (genvar l = 0; l < 4; l++) begin : g_col
    ks_qround u_col (
      .a_i(s_i[l]),    .b_i(s_i[4+l]),  .c_i(s_i[8+l]),  .d_i(s_i[12+l]),
      .a_o(col[l]),    .b_o(col[4+l]),  .c_o(col[8+l]),  .d_o(col[12+l])
    );
  end

  // diagonal pass: row r contributes lane (l+r) mod 4; writing results back
  // to the same lanes stands in for the rotate / unrotate of the rows
  for (genvar l = 0; l < 4; l++) begin : g_diag
    localparam int L1 = (l + 1) % 4;
    localparam int L2 = (l + 2) % 4;
    localparam int L3 = (l + 3) % 4;
    ks_qround u_diag (
      .a_i(col[l]),    .b_i(col[4+L1]),  .c_i(col[8+L2]),  .d_i(col[12+L3]),
      .a_o(s_o[l]),    .b_o(s_o[4+L1]),  .c_o(s_o[8+L2]),  .d_o(s_o[12+L3])
    );
  end

endmodule

// File: rtl/chacha_kstream_gen.sv
module chacha_kstream_gen
  import chacha_kstream_pkg::*;
#(
  parameter int ROUNDS = 20,
  parameter int NBLK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [255:0]      key_i,
  input  logic [63:0]       ctr_i,
  input  logic [NBLK_W-1:0] nblk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       word_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [63:0]       ctr_o
);

  localparam int DR   = ROUNDS / 2;
  localparam int DR_W = (DR > 1) ? $clog2(DR) : 1;

  ks_state_t          st_q;
  logic [DR_W-1:0]    rcnt_q;
  logic [IDX_W-1:0]   widx_q;
  blk_t               work_q;
  logic [KEY_W-1:0]   key_q;
  logic [CTR_W-1:0]   ctr_q;
  logic [NBLK_W-1:0]  left_q;
  logic               done_q;

  blk_t dr_out;
  blk_t init_cur;
  blk_t init_next;

  // named events, also used by the bound checker
  logic start_take, round_last, accept, word_last, block_end, job_end;
  logic work_zero, key_zero;

  ks_dround u_dround (
    .s_i(work_q),
    .s_o(dr_out)
  );

  assign init_cur   = init_state(key_q, ctr_q);
  assign init_next  = init_state(key_q, ctr_q + CTR_W'(1));

  assign start_take = (st_q == ST_IDLE) && start_i;
  assign round_last = (st_q == ST_ROUND) && (rcnt_q == DR_W'(DR - 1));
  assign accept     = (st_q == ST_EMIT) && ready_i;
  assign word_last  = (widx_q == IDX_W'(N_WORDS - 1));
  assign block_end  = accept && word_last;
  assign job_end    = block_end && (left_q == NBLK_W'(1));
  assign work_zero  = (work_q == '0);
  assign key_zero   = (key_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      rcnt_q <= '0;
      widx_q <= '0;
      work_q <= '0;
      key_q  <= '0;
      ctr_q  <= '0;
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= job_end;
      case (st_q)
        ST_IDLE: begin
          if (start_take) begin
            key_q  <= key_i;
            ctr_q  <= ctr_i;
            left_q <= nblk_i;
            work_q <= init_state(key_i, ctr_i);
            rcnt_q <= '0;
            st_q   <= ST_ROUND;
          end
        end
        ST_ROUND: begin
          work_q <= dr_out;
          if (round_last) begin
            rcnt_q <= '0;
            widx_q <= '0;
            st_q   <= ST_EMIT;
          end else begin
            rcnt_q <= rcnt_q + DR_W'(1);
          end
        end
        ST_EMIT: begin
          if (accept) begin
            widx_q <= widx_q + IDX_W'(1);
            if (word_last) begin
              ctr_q  <= ctr_q + CTR_W'(1);
              left_q <= left_q - NBLK_W'(1);
              if (job_end) begin
                work_q <= '0;
                key_q  <= '0;
                st_q   <= ST_IDLE;
              end else begin
                work_q <= init_next;
                st_q   <= ST_ROUND;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign valid_o = (st_q == ST_EMIT);
  assign done_o  = done_q;
  assign ctr_o   = ctr_q;
  // feed-forward add is done at the output, one word at a time
  assign word_o  = valid_o ? (work_q[widx_q] + init_cur[widx_q]) : '0;

endmodule

// File: rtl/chacha_kstream_chk.sv
module chacha_kstream_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        valid,
  input logic        ready,
  input logic [31:0] word,
  input logic [63:0] ctr,
  input logic        round_last,
  input logic        word_last,
  input logic        work_zero,
  input logic        key_zero
);

  a_r1_valid_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> busy);

  a_r3_emit_after_rounds: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(round_last));

  a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(word)));

  a_r5_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && word_last) |=> (ctr == $past(ctr) + 64'd1));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(valid && ready && word_last) && !busy));

  a_r9_wiped: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (work_zero && key_zero));

endmodule

bind chacha_kstream_gen chacha_kstream_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .busy(busy_o),
  .done(done_o),
  .valid(valid_o),
  .ready(ready_i),
  .word(word_o),
  .ctr(ctr_o),
  .round_last(round_last),
  .word_last(word_last),
  .work_zero(work_zero),
  .key_zero(key_zero)
);

// File: tb/chacha_kstream_gen_tb_top.sv
`timescale 1ns/1ps
module chacha_kstream_gen_tb_top;

  localparam int NBLK_W = 16;

  typedef logic [31:0] arr_t [16];

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [255:0]      key_i = '0;
  logic [63:0]       ctr_i = '0;
  logic [NBLK_W-1:0] nblk_i = '0;
  logic              busy_o, done_o, valid_o;
  logic              ready_i = 1'b0;
  logic [31:0]       word_o;
  logic [63:0]       ctr_o;

  int n_checks = 0;
  int n_fail = 0;
  int jobs_done = 0;
  int ready_mode = 0;
  int gap_cnt = 0;
  logic prev_valid = 1'b0;
  logic [63:0] exp_ctr = '0;
  logic [31:0] exp_q [$];
  int unsigned lf = 32'h1234_5678;

  always #2 clk = ~clk;

  chacha_kstream_gen #(.ROUNDS(20), .NBLK_W(NBLK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .key_i(key_i),
    .ctr_i(ctr_i), .nblk_i(nblk_i), .busy_o(busy_o), .done_o(done_o),
    .word_o(word_o), .valid_o(valid_o), .ready_i(ready_i), .ctr_o(ctr_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- independent reference model ----------------
  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic arr_t qr(input arr_t x, input int a, input int b, input int c, input int d);
    arr_t y = x;
    y[a] = y[a] + y[b]; y[d] = rl(y[d] ^ y[a], 16);
    y[c] = y[c] + y[d]; y[b] = rl(y[b] ^ y[c], 12);
    y[a] = y[a] + y[b]; y[d] = rl(y[d] ^ y[a], 8);
    y[c] = y[c] + y[d]; y[b] = rl(y[b] ^ y[c], 7);
    return y;
  endfunction

  function automatic arr_t ref_block(input logic [255:0] key, input logic [63:0] ctr);
    arr_t x, s;
    x[0] = 32'h61707865; x[1] = 32'h3320646e; x[2] = 32'h79622d32; x[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) x[4+i] = key[32*i +: 32];
    x[12] = ctr[31:0]; x[13] = ctr[63:32]; x[14] = '0; x[15] = '0;
    s = x;
    for (int r = 0; r < 10; r++) begin
      x = qr(x, 0, 4, 8, 12);  x = qr(x, 1, 5, 9, 13);
      x = qr(x, 2, 6, 10, 14); x = qr(x, 3, 7, 11, 15);
      x = qr(x, 0, 5, 10, 15); x = qr(x, 1, 6, 11, 12);
      x = qr(x, 2, 7, 8, 13);  x = qr(x, 3, 4, 9, 14);
    end
    for (int i = 0; i < 16; i++) x[i] = x[i] + s[i];
    return x;
  endfunction

  // ---------------- ready driver ----------------
  always begin
    @(posedge clk);
    #1;
    lf = lf * 32'd1103515245 + 32'd12345;
    case (ready_mode)
      0: ready_i = 1'b1;
      1: ready_i = lf[16];
      default: ready_i = (lf[17:16] == 2'b11);
    endcase
  end

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && ready_i) begin
        if (exp_q.size() == 0) chk("R4 unexpected word", {32'h0, word_o}, 64'hdead);
        else chk("R4 word", {32'h0, word_o}, {32'h0, exp_q.pop_front()});
      end
      // R3, R6: mixing gap before every block
      if (valid_o && !prev_valid) chk("R3,R6 gap", gap_cnt, 10);
      if (busy_o && !valid_o) gap_cnt++;
      else gap_cnt = 0;
      if (!valid_o) chk("R9 idle word", {32'h0, word_o}, 64'h0);
      if (done_o) begin
        chk("R7 ctr_o", ctr_o, exp_ctr);
        chk("R7 busy low", {63'h0, busy_o}, 64'h0);
        chk("R7 all words", exp_q.size(), 0);
        // R9 wipe is asserted internally at this point
        jobs_done++;
      end
      prev_valid = valid_o;
    end
  end

  task automatic run_job(input logic [255:0] key, input logic [63:0] ctr,
                         input int n, input int mode, input bit inject);
    arr_t b;
    int target;
    ready_mode = mode;
    for (int k = 0; k < n; k++) begin
      b = ref_block(key, ctr + 64'(k));
      for (int w = 0; w < 16; w++) exp_q.push_back(b[w]);
    end
    exp_ctr = ctr + 64'(n);
    target = jobs_done + 1;
    @(posedge clk); #1;
    key_i = key; ctr_i = ctr; nblk_i = NBLK_W'(n); start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (inject) begin
      repeat (3) @(posedge clk);
      #1;
      key_i = ~key; ctr_i = ~ctr; nblk_i = NBLK_W'(5); start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      chk("R8 still busy", {63'h0, busy_o}, 64'h1);
      chk("R8 ctr unchanged", ctr_o, ctr);
    end
    while (jobs_done < target) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [255:0] kpat;
    arr_t z;
    for (int i = 0; i < 8; i++) kpat[32*i +: 32] = 32'h03020100 + 32'h04040404 * i;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {63'h0, busy_o}, 64'h0);
    chk("R1 reset valid", {63'h0, valid_o}, 64'h0);
    chk("R1 reset done", {63'h0, done_o}, 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset busy", {63'h0, busy_o}, 64'h0);

    // R2: model agrees with the well-known all-zero key/counter keystream
    z = ref_block('0, '0);
    chk("R2 model vector", {32'h0, z[0]}, {32'h0, 32'hade0b876});

    run_job('0, 64'h0, 1, 0, 1'b0);                             // R2, R4
    run_job(kpat, 64'h5, 3, 1, 1'b1);                           // R5, R6, R8
    run_job(~kpat, 64'h0000_0000_ffff_ffff, 2, 0, 1'b0);        // R5 carry
    run_job(kpat ^ {8{32'h5a5a_a5a5}}, 64'hffff_ffff_ffff_ffff, 2, 1, 1'b0); // R5 wrap
    run_job({8{32'hdead_beef}}, 64'h1234_5678_9abc_def0, 1, 2, 1'b0);       // R4 stalls

    repeat (3) @(negedge clk);
    chk("R7 idle after jobs", {63'h0, busy_o}, 64'h0);
    finish_up();
  end

endmodule